// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two data buses, A and B, of the same width. Each bus is modelled as three separate vectors: an input, an output and an output-enable. This keeps the core free of tri-state logic, and a pad wrapper can merge the three into a real pin if needed. Each transfer direction has its own holding register. The register for the A-to-B direction samples bus A, and the register for the B-to-A direction samples bus B. Each register loads on a rising edge of its own capture strobe. Both strobes are sampled on the core clock. A capture takes place whatever the enable, direction and select inputs are doing.

An active-low enable and a direction input decide which port, if any, drives its bus. A per-direction select then chooses what that port drives:
- Select low: the live value on the opposite bus input.
- Select high: the value held in that direction's register.

The control inputs are decoded into a registered mode state. The output multiplexer is therefore steered by one clean, stable state value rather than by a decode of several raw pins. The mode state machine has five states:

| State | Meaning | Entered when (sampled at a clock edge) |
|---|---|---|
| `M_ISOLATE` | No port drives; reset state | enable high |
| `M_B2A_LIVE` | Port A drives with `b_in` | enable low, direction low, `sel_ba` low |
| `M_B2A_STORED` | Port A drives with the B-to-A register | enable low, direction low, `sel_ba` high |
| `M_A2B_LIVE` | Port B drives with `a_in` | enable low, direction high, `sel_ab` low |
| `M_A2B_STORED` | Port B drives with the A-to-B register | enable low, direction high, `sel_ab` high |

Each clock edge moves the state machine directly to the state that matches the sampled inputs, from any state.

Top module: `bus_xfer_xcvr`

## Requirements
- R1: With `oe_n` high at a clock edge, after that edge both `a_oe` and `b_oe` are all zeros and both `a_out` and `b_out` read zero (isolation).
- R2: With `oe_n` low and `dir` low at an edge, after that edge `a_oe` is all ones and `b_oe` is all zeros.
- R3: With `oe_n` low and `dir` high at an edge, after that edge `b_oe` is all ones and `a_oe` is all zeros.
- R4: In a live mode (the select for the active direction is low), the driven output follows the opposite bus input in the same cycle, with no clock edge between them.
- R5: In a stored mode (that select is high), the driven output equals the register of that direction: the B-to-A register on `a_out`, the A-to-B register on `b_out`.
- R6: A clock edge that sees `cap_ab` high after it was low at the previous edge loads `a_in` into the A-to-B register. While `cap_ab` stays high, that register keeps its value.
- R7: The same rule as R6 applies to `cap_ba`, `b_in` and the B-to-A register.
- R8: Captures take place whatever the values of `oe_n`, `dir`, `sel_ab` and `sel_ba`, including during isolation.
- R9: `a_oe` and `b_oe` are never nonzero in the same cycle.
- R10: A change on `oe_n`, `dir` or a select reaches the outputs only after the next clock edge. Before that edge, the outputs keep their previous mode.
- R11: Synchronous active-high `rst` clears both registers and both strobe histories, and puts the mode in isolation.
- R12: Rising edges on both strobes at the same clock edge load both registers together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_ab | input | 1 | Capture strobe: bus A into the A-to-B register |
| cap_ba | input | 1 | Capture strobe: bus B into the B-to-A register |
| oe_n | input | 1 | Transceiver enable, active low |
| dir | input | 1 | Direction: 0 = port A drives, 1 = port B drives |
| sel_ab | input | 1 | Port B source: 0 = live `a_in`, 1 = A-to-B register |
| sel_ba | input | 1 | Port A source: 0 = live `b_in`, 1 = B-to-A register |
| a_in | input | W | Bus A input |
| a_out | output | W | Bus A output data |
| a_oe | output | W | Bus A output-enable, per bit |
| b_in | input | W | Bus B input |
| b_out | output | W | Bus B output data |
| b_oe | output | W | Bus B output-enable, per bit |

## Verification
Control results (R1, R2, R3, R5, R10) are due one clock edge after the inputs change. The bench therefore drives the control inputs on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. R10 also gets a sample taken before that rising edge, to show that the old mode still holds. Captured values appear right after the edge that sees the strobe's rising transition, and the bench reads them out through a stored mode one edge later. Live data (R4) has no register on its path, so the bench changes the bus input between edges and samples a nanosecond later without any clock edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [2:0] {
        M_ISOLATE    = 3'd0,
        M_B2A_LIVE   = 3'd1,
        M_B2A_STORED = 3'd2,
        M_A2B_LIVE   = 3'd3,
        M_A2B_STORED = 3'd4
    } xmode_e;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic strobe_q;
    logic load;

    assign load = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            if (load) begin
                q <= d;
            end
        end
    end

    // R6 / R7: a fresh strobe rise loads the bus value
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        (strobe && !strobe_q) |=> (q == $past(d)));

    // R6 / R7: without a fresh rise the register holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !(strobe && !strobe_q) |=> $stable(q));

endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
    import xcvr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   oe_n,
    input  logic   dir,
    input  logic   sel_ab,
    input  logic   sel_ba,
    output xmode_e mode
);

    xmode_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= M_ISOLATE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case ({oe_n, dir})
            2'b00:   state_nx = sel_ba ? M_B2A_STORED : M_B2A_LIVE;
            2'b01:   state_nx = sel_ab ? M_A2B_STORED : M_A2B_LIVE;
            default: state_nx = M_ISOLATE;
        endcase
    end

    assign mode = state;

    // R11: reset leaves the machine isolated
    a_r11_reset_iso: assert property (@(posedge clk)
        rst |=> (state == M_ISOLATE));

    // R10: the registered mode tracks the sampled controls one edge later
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir && sel_ab) |=> (state == M_A2B_STORED));

endmodule

// File: rtl/bus_xfer_xcvr.sv
module bus_xfer_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    localparam logic [W-1:0] ALL_ON = {W{1'b1}};

    logic [W-1:0] reg_ab;
    logic [W-1:0] reg_ba;
    xmode_e       mode;

    xcvr_capture #(.W(W)) u_cap_ab (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_ab),
        .d      (a_in),
        .q      (reg_ab)
    );

    xcvr_capture #(.W(W)) u_cap_ba (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_ba),
        .d      (b_in),
        .q      (reg_ba)
    );

    xcvr_mode_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .mode   (mode)
    );

    always_comb begin
        a_out = '0;
        a_oe  = '0;
        b_out = '0;
        b_oe  = '0;
        unique case (mode)
            M_B2A_LIVE: begin
                a_out = b_in;
                a_oe  = ALL_ON;
            end
            M_B2A_STORED: begin
                a_out = reg_ba;
                a_oe  = ALL_ON;
            end
            M_A2B_LIVE: begin
                b_out = a_in;
                b_oe  = ALL_ON;
            end
            M_A2B_STORED: begin
                b_out = reg_ab;
                b_oe  = ALL_ON;
            end
            default: begin
                a_out = '0;
            end
        endcase
    end

    // R1: isolation releases both buses
    a_r1_isolate: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> ((a_oe == '0) && (b_oe == '0)));

    // R2: port A takes the bus
    a_r2_drive_a: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir) |=> ((a_oe == ALL_ON) && (b_oe == '0)));

    // R3: port B takes the bus
    a_r3_drive_b: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir) |=> ((b_oe == ALL_ON) && (a_oe == '0)));

    // R4: live data passes straight through
    a_r4_live_a: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir && !sel_ba) |=> (a_out == b_in));

    // R9: never two drivers
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !((a_oe != '0) && (b_oe != '0)));

endmodule

// File: tb/sim_bus_xfer_xcvr.sv
module sim_bus_xfer_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         cap_ab, cap_ba, oe_n, dir, sel_ab, sel_ba;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    bus_xfer_xcvr #(.W(W)) u0 (
        .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // {oe_n,dir,sel_ab,sel_ba}, exp a_oe, exp b_oe, exp a_out, exp b_out
    // with a_in=11, b_in=22, A-to-B reg=3C, B-to-A reg=A5
    localparam logic [21:0] TBL [16] = '{
        {4'd0,  2'b10, 8'h22, 8'h00},
        {4'd1,  2'b10, 8'hA5, 8'h00},
        {4'd2,  2'b10, 8'h22, 8'h00},
        {4'd3,  2'b10, 8'hA5, 8'h00},
        {4'd4,  2'b01, 8'h00, 8'h11},
        {4'd5,  2'b01, 8'h00, 8'h11},
        {4'd6,  2'b01, 8'h00, 8'h3C},
        {4'd7,  2'b01, 8'h00, 8'h3C},
        {4'd8,  2'b00, 8'h00, 8'h00},
        {4'd9,  2'b00, 8'h00, 8'h00},
        {4'd10, 2'b00, 8'h00, 8'h00},
        {4'd11, 2'b00, 8'h00, 8'h00},
        {4'd12, 2'b00, 8'h00, 8'h00},
        {4'd13, 2'b00, 8'h00, 8'h00},
        {4'd14, 2'b00, 8'h00, 8'h00},
        {4'd15, 2'b00, 8'h00, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic on_n, input logic d, input logic sab, input logic sba);
        oe_n = on_n; dir = d; sel_ab = sab; sel_ba = sba;
    endtask

    task automatic load_both(input logic [W-1:0] av, input logic [W-1:0] bv);
        a_in = av; b_in = bv; cap_ab = 1'b1; cap_ba = 1'b1;
        tick();
        cap_ab = 1'b0; cap_ba = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=5000", cyc);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cap_ab = 1'b0; cap_ba = 1'b0;
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        a_in = 8'h00; b_in = 8'h00;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R11: reset state is isolated
        chk("R11 oe after reset", {a_oe, b_oe}, 32'h0);

        // R11: registers cleared, seen through stored modes
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1); b_in = 8'h77;
        tick();
        chk("R11 B-to-A reg cleared", a_out, 32'h0);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0); a_in = 8'h66;
        tick();
        chk("R11 A-to-B reg cleared", b_out, 32'h0);

        // R12 + R8: load both together while isolated
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        load_both(8'h3C, 8'hA5);
        a_in = 8'h11; b_in = 8'h22;

        // Table walk: every enable/direction/select combination
        for (int i = 0; i < 16; i++) begin
            logic [21:0] e;
            e = TBL[i];
            set_ctl(e[21], e[20], e[19], e[18]);
            tick();
            chk(e[21] ? "R1 oe" : (e[20] ? "R3 oe" : "R2 oe"),
                {a_oe[0], b_oe[0], a_oe, b_oe}, {e[17], e[16], {W{e[17]}}, {W{e[16]}}});
            chk(e[21] ? "R1 data" : ((e[20] ? e[19] : e[18]) ? "R5 data" : "R4 data"),
                {a_out, b_out}, {e[15:8], e[7:0]});
            chk("R9 exclusive", {31'd0, (a_oe != '0) && (b_oe != '0)}, 32'h0);
        end

        // R4: live output follows the input without a clock edge
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        tick();
        a_in = 8'h5A;
        #1;
        chk("R4 live follow A to B", b_out, 32'h5A);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        b_in = 8'hC3;
        #1;
        chk("R4 live follow B to A", a_out, 32'hC3);

        // R10: control change waits for the next edge
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R10 still driving before edge", a_oe, 32'hFF);
        tick();
        chk("R10 isolated after edge", a_oe, 32'h0);

        // R6: held strobe loads only once; capture while isolated (R8)
        a_in = 8'h81; cap_ab = 1'b1;
        tick();
        a_in = 8'h42;
        tick(); tick();
        cap_ab = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R6 held strobe keeps first value", b_out, 32'h81);

        // R7 + R8: B-to-A capture while port B drives stored data
        b_in = 8'h9E; cap_ba = 1'b1;
        tick();
        cap_ba = 1'b0; b_in = 8'h00;
        chk("R8 A-to-B unchanged by other capture", b_out, 32'h81);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        chk("R7 B-to-A captured", a_out, 32'h9E);

        // R11: reset mid-run clears stored data
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R11 isolated during reset", a_oe, 32'h0);
        tick();
        chk("R11 B-to-A cleared by reset", a_out, 32'h0);

        finish_run();
    end

endmodule